// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that runs on a slow subsystem clock. It has one byte-wide control register. The upper five bits of that register are a keyed enable field and the lower three bits pick one of eight time-out lengths. While the watchdog is armed, a free-running divider counts slow-clock cycles. If software does not restart the count in time, the block raises a one-cycle reset request.

The enable field accepts only two codes: one arms the watchdog and one stops it. Any other value is treated as corruption of the register. In that case the block raises a reset request two slow-clock cycles later and keeps it raised for as long as the bad value stays. It also sets a sticky status flag. Software can read that flag after the system restarts, and only software can clear it. The block's own reset input is the power-on reset. The reset request is a separate output that goes to the system reset generator, so the flag is kept through any reset it caused.

Top module: `keyed_wdt`

## Requirements
- R1: While `rst` is high and after it is released, `ctrl_rdata` reads 0x53 (key 01010 in bits 7..3, select 011 in bits 2..0), `stat_rdata` reads 0x00 and `rst_req` is low.
- R2: `ctrl_rdata` returns the byte last written through `ctrl_we`/`ctrl_wdata`, from the cycle after the write.
- R3: With key 01010 in bits 7..3, select codes 000..111 in bits 2..0 give time-outs of 2^8, 2^10, 2^12, 2^14, 2^15, 2^16, 2^17 and 2^18 clock cycles. These are counted from reset release, from a control write, from a `kick`, or from the previous time-out, up to the cycle in which `rst_req` rises.
- R4: A time-out drives `rst_req` high for exactly one cycle. The divider then restarts from zero, so time-outs repeat at the selected period.
- R5: A `kick` pulse clears the divider, and the next time-out comes a full period after the kick.
- R6: Any control-register write clears the divider, even if it rewrites the same value.
- R7: With key 10101 in bits 7..3 the divider is held at zero and `rst_req` stays low.
- R8: A key that is neither 01010 nor 10101 raises `rst_req` exactly two cycles after the write that stored it. `rst_req` stays high while the key stays illegal and falls within three cycles after a legal key is written.
- R9: The flag in bit 0 of `stat_rdata` goes to 1 in the same cycle that an illegal-key reset request rises. Bits 7..1 of `stat_rdata` always read 0.
- R10: A status write (`stat_we`) with `stat_wdata[0]`=0 clears the flag. A status write with bit 0 = 1 has no effect. The flag is never cleared any other way except by `rst`, so it outlasts the reset request it records.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow subsystem clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data: key [7:3], select [2:0] |
| ctrl_rdata | output | 8 | Control register read data |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data; bit 0 = 0 clears the flag |
| stat_rdata | output | 8 | Status read data; bit 0 is the sticky illegal-key flag |
| kick | input | 1 | Software clear pulse that restarts the divider |
| rst_req | output | 1 | Reset request to the system reset generator |

## Verification
The hardest situation to reach is a corrupted enable key, because in real operation it comes only from a disturbed register. The bench gets there by writing illegal key codes straight through the control port. It then samples `rst_req` and the status flag on each of the next three cycles, so the exact two-cycle latency is checked. Next it writes a legal key again and confirms that the flag survives and that only a clearing status write removes it. The long time-outs are not all run to completion. Instead the default select code is timed from reset release, and the three shortest codes are timed exactly.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int REG_W = 8;
    localparam int KEY_W = 5;
    localparam int SEL_W = 3;
    localparam int CNT_W = 18;

    localparam logic [KEY_W-1:0] KEY_ARM  = 5'b01010;
    localparam logic [KEY_W-1:0] KEY_STOP = 5'b10101;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        KS_STOP  = 2'd0,
        KS_ARMED = 2'd1,
        KS_BAD   = 2'd2
    } key_state_e;

    localparam ctrl_t CTRL_POR = '{key: KEY_ARM, sel: 3'b011};

    function automatic key_state_e classify_key(logic [KEY_W-1:0] k);
        if (k == KEY_ARM)       return KS_ARMED;
        else if (k == KEY_STOP) return KS_STOP;
        else                    return KS_BAD;
    endfunction

    function automatic int period_log2(logic [SEL_W-1:0] s);
        case (s)
            3'd0:    return 8;
            3'd1:    return 10;
            3'd2:    return 12;
            3'd3:    return 14;
            3'd4:    return 15;
            3'd5:    return 16;
            3'd6:    return 17;
            default: return 18;
        endcase
    endfunction

    // last count value before wrap: 2^n - 1
    function automatic logic [CNT_W-1:0] last_count(logic [SEL_W-1:0] s);
        logic [CNT_W-1:0] t;
        int n;
        n = period_log2(s);
        t = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < n) t[i] = 1'b1;
        end
        return t;
    endfunction

endpackage

// File: rtl/kwdt_ctrl_reg.sv
module kwdt_ctrl_reg
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output key_state_e       kstate
);
    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= CTRL_POR;
        else if (we) ctrl_q <= ctrl_t'(wdata);
    end

    always_comb kstate = classify_key(ctrl_q.key);
endmodule

// File: rtl/kwdt_divider.sv
module kwdt_divider
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb limit = last_count(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (clear || !run) begin
                cnt_q <= '0;
            end else if (cnt_q == limit) begin
                cnt_q   <= '0;
                expired <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/kwdt_key_monitor.sv
module kwdt_key_monitor
    import kwdt_pkg::*;
#(
    parameter int FAULT_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bad_key,
    input  logic flag_clr,
    output logic fault_req,
    output logic flag_q
);
    logic [FAULT_DLY-1:0] pipe_q;
    logic [FAULT_DLY-1:0] pipe_d;

    generate
        if (FAULT_DLY == 1) begin : g_one
            always_comb pipe_d = bad_key;
        end else begin : g_many
            always_comb pipe_d = {pipe_q[FAULT_DLY-2:0], bad_key};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign fault_req = pipe_q[FAULT_DLY-1];

    // set wins over a simultaneous software clear
    always_ff @(posedge clk) begin
        if (rst)                       flag_q <= 1'b0;
        else if (pipe_d[FAULT_DLY-1])  flag_q <= 1'b1;
        else if (flag_clr)             flag_q <= 1'b0;
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    input  logic       stat_we,
    input  logic [7:0] stat_wdata,
    output logic [7:0] stat_rdata,
    input  logic       kick,
    output logic       rst_req
);
    ctrl_t      ctrl_q;
    key_state_e kstate;
    logic       key_bad;
    logic       key_off;
    logic       to_pulse;
    logic       fault_req;
    logic       flag_q;

    kwdt_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .we     (ctrl_we),
        .wdata  (ctrl_wdata),
        .ctrl_q (ctrl_q),
        .kstate (kstate)
    );

    assign key_bad = (kstate == KS_BAD);
    assign key_off = (kstate == KS_STOP);

    kwdt_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (kstate == KS_ARMED),
        .clear   (kick | ctrl_we),
        .sel     (ctrl_q.sel),
        .expired (to_pulse)
    );

    kwdt_key_monitor #(.FAULT_DLY(2)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .bad_key   (key_bad),
        .flag_clr  (stat_we & ~stat_wdata[0]),
        .fault_req (fault_req),
        .flag_q    (flag_q)
    );

    assign ctrl_rdata = ctrl_q;
    assign stat_rdata = {7'b0, flag_q};
    assign rst_req    = to_pulse | fault_req;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata,
    input logic       stat_we,
    input logic [7:0] stat_wdata,
    input logic [7:0] stat_rdata,
    input logic       rst_req,
    input logic       key_bad,
    input logic       key_off,
    input logic       to_pulse,
    input logic       fault_req
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)             cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(ctrl_we)) |-> ctrl_rdata == $past(ctrl_wdata));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        to_pulse |=> !to_pulse);

    // R7
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(key_off)) |-> !to_pulse);

    // R8
    bad_key_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(key_bad, 2)) |-> rst_req);

    // R9
    flag_with_fault_chk: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> stat_rdata[0]);

    // R9
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[7:1] == 7'd0);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(stat_rdata[0]) &&
         !($past(stat_we) && !$past(stat_wdata[0]))) |-> stat_rdata[0]);
endmodule

bind keyed_wdt kwdt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .stat_rdata (stat_rdata),
    .rst_req    (rst_req),
    .key_bad    (key_bad),
    .key_off    (key_off),
    .to_pulse   (to_pulse),
    .fault_req  (fault_req)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctrl_we;
    logic [7:0] ctrl_wdata;
    logic [7:0] ctrl_rdata;
    logic       stat_we;
    logic [7:0] stat_wdata;
    logic [7:0] stat_rdata;
    logic       kick;
    logic       rst_req;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyed_wdt u_keyed_wdt (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .stat_rdata (stat_rdata),
        .kick       (kick),
        .rst_req    (rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        stat_we = 1'b1; stat_wdata = v;
        @(negedge clk);
        stat_we = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // cycles from the last restart edge until rst_req is seen high
    task automatic time_out(input string req, input int exp, input int start);
        int n = start;
        while (!rst_req && n <= exp + 4) begin
            @(negedge clk);
            n++;
        end
        check(rst_req && n == exp, req, n, exp);
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        // R1
        check(ctrl_rdata == 8'h53, "R1 ctrl", ctrl_rdata, 8'h53);
        check(stat_rdata == 8'h00, "R1 stat", stat_rdata, 8'h00);
        check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
    endtask

    task automatic t_por_period();
        rst = 1'b0;
        check(ctrl_rdata == 8'h53, "R1 ctrl after release", ctrl_rdata, 8'h53);
        time_out("R3 default select 011", 16384, 0);
        @(negedge clk);
        check(rst_req == 1'b0, "R4 one-cycle pulse", rst_req, 0);
        time_out("R4 periodic restart", 16384, 1);
    endtask

    task automatic t_readback();
        wr_ctrl(8'hAD);
        check(ctrl_rdata == 8'hAD, "R2 readback", ctrl_rdata, 8'hAD);
        wr_ctrl(8'h51);
        check(ctrl_rdata == 8'h51, "R2 readback", ctrl_rdata, 8'h51);
    endtask

    task automatic t_select();
        wr_ctrl(8'h50);
        time_out("R3 select 000", 256, 0);
        wr_ctrl(8'h51);
        time_out("R3 select 001", 1024, 0);
        wr_ctrl(8'h52);
        time_out("R3 select 010", 4096, 0);
    endtask

    task automatic t_kick();
        int seen = 0;
        wr_ctrl(8'h50);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        do_kick();
        check(seen == 0, "R5 no early time-out", seen, 0);
        time_out("R5 period after kick", 256, 0);
    endtask

    task automatic t_rewrite();
        wr_ctrl(8'h50);
        idle(200);
        wr_ctrl(8'h50);
        time_out("R6 period after rewrite", 256, 0);
    endtask

    task automatic t_stopped();
        int seen = 0;
        wr_ctrl(8'hA8);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        check(seen == 0, "R7 stopped, no request", seen, 0);
    endtask

    task automatic t_bad_key(input logic [7:0] v);
        wr_ctrl(v);
        check(rst_req == 1'b0, "R8 +0 cycles", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1'b0, "R8 +1 cycle", rst_req, 0);
        @(negedge clk);
        check(rst_req == 1'b1, "R8 +2 cycles", rst_req, 1);
        check(stat_rdata == 8'h01, "R9 flag with request", stat_rdata, 8'h01);
        idle(5);
        check(rst_req == 1'b1, "R8 held while illegal", rst_req, 1);
        wr_ctrl(8'hA8);
        idle(3);
        check(rst_req == 1'b0, "R8 released after repair", rst_req, 0);
        check(stat_rdata == 8'h01, "R10 flag outlasts request", stat_rdata, 8'h01);
    endtask

    task automatic t_flag_clear();
        wr_stat(8'hFF);
        check(stat_rdata == 8'h01, "R10 write of 1 ignored", stat_rdata, 8'h01);
        wr_stat(8'hFE);
        check(stat_rdata == 8'h00, "R10 cleared by software", stat_rdata, 8'h00);
        wr_stat(8'h01);
        check(stat_rdata == 8'h00, "R10 software cannot set", stat_rdata, 8'h00);
    endtask

    initial begin
        rst = 1'b1; ctrl_we = 1'b0; ctrl_wdata = 8'h00;
        stat_we = 1'b0; stat_wdata = 8'h00; kick = 1'b0;
        idle(3);
        t_reset();
        t_por_period();
        t_readback();
        t_select();
        t_kick();
        t_rewrite();
        t_stopped();
        t_bad_key(8'h03);
        t_flag_clear();
        t_bad_key(8'hFA);
        t_flag_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule